// File: doc/BRIEF.md
# Split-Line Memory Permission Checker

This block judges every bus access against a permission map that is split by address. An instruction window is cut into four areas by three programmable split lines. A data window is also cut into four areas, by two data split lines plus the main instruction line moved into data address space by a fixed offset. Each instruction area has its own read, write and execute enables. Each data area has only read and write enables. For each access the block finds the area the address falls in, looks up the enable for the requested operation, and raises `violation` in the same cycle when that operation is not allowed.

A small write-only register port loads the split lines, the permission fields, the monitor enables and three sticky lock bits. Split lines are kept at 512-byte granularity. Once a lock bit is set, the fields it guards cannot be changed again until reset. Software first programs the lines and the permissions, then enables monitoring, and finally locks the configuration.

Top module: `spl_perm_checker`

## Requirements
- R1: After reset every line, permission field, lock bit and monitor enable is zero, so no access raises `violation`.
- R2: Register indices 0, 1 and 2 hold instruction line 0, line 1 and the main line. Indices 3 and 4 hold data line 0 and data line 1. Only `cfg_wdata` bits 31..9 are stored, so the boundary is the written value with its low 9 bits cleared.
- R3: An instruction address below line 0 is in area 0. From line 0 up to line 1 it is in area 1. From line 1 up to the main line it is in area 2. At or above the main line it is in area 3. When two lines overlap, the higher-numbered line wins. Comparisons are unsigned, and an address equal to a boundary belongs to the upper area.
- R4: Register index 7 holds the locks. Bit 0 is the split lock, bit 1 the instruction-permission lock and bit 2 the data-permission lock. While the split lock is set, writes to indices 0 to 4 are ignored.
- R5: Writing a 1 to a lock bit sets it. Writing a 0 to the lock register does not clear any bit that is already set. Only reset clears the locks.
- R6: While the instruction-permission lock is set, writes to index 5 are ignored. While the data-permission lock is set, writes to index 6 are ignored. Each lock guards only its own field.
- R7: Index 5 holds the instruction permissions: area k uses bits [3k+2:3k], with bit 3k for read, bit 3k+1 for write and bit 3k+2 for execute. `acc_op` is 0 for read, 1 for write and 2 for execute. An instruction access violates when the enable for its operation in its area is 0. Operation code 3 always violates.
- R8: Data accesses (`acc_dwin`=1) use the boundaries data line 0, data line 1, and the main line plus DATA_OFFSET (default 0x0010_0000), with the same area rule as R3. Index 6 holds the data permissions: area k uses bits [2k+1:2k], with bit 2k for read and bit 2k+1 for write. A data execute access always violates.
- R9: `violation` is combinational and follows the access in the same cycle. It is 0 when `acc_valid` is 0. Index 8 holds the monitor enables, bit 0 for the instruction window and bit 1 for the data window. When the monitor enable of the accessed window is 0, `violation` is 0. The monitor enables are not lockable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access request present |
| acc_dwin | input | 1 | 1 = data window, 0 = instruction window |
| acc_op | input | 2 | 0 read, 1 write, 2 execute |
| acc_addr | input | 32 | Access address |
| violation | output | 1 | Requested operation not permitted |

## Verification
All configuration state can be seen only through `violation`. A wrong split line shows up as a wrong area choice at addresses right next to a boundary. For that reason the bench probes each boundary address and the address one below it, using permissions that differ from one area to the next. A lost or leaking lock shows up on the first access after a blocked write, because the bench chooses its blocked values so that they would flip the verdict at a probed address. Since the output is combinational, any such fault is visible in the first access cycle after the offending write.

// File: rtl/spl_pkg.sv
package spl_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_EXEC  = 2'd2,
      OP_BAD   = 2'd3
   } spl_op_e;

   localparam int LOCK_SPLIT = 0;
   localparam int LOCK_IPERM = 1;
   localparam int LOCK_DPERM = 2;
   localparam int LOCK_BITS  = 3;

   localparam int MON_INS = 0;
   localparam int MON_DAT = 1;
endpackage

// File: rtl/spl_area_decode.sv
module spl_area_decode #(
   parameter int ADDR_W = 32,
   parameter int NB     = 3,
   parameter int AREA_W = 2
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NB-1:0][ADDR_W-1:0] bnd,
   output logic [AREA_W-1:0]         area
);
   generate
      if ((1 << AREA_W) < NB + 1) begin : g_bad_w
         $error("AREA_W too small for NB boundaries");
      end
   endgenerate

   logic [NB-1:0] at_or_above;

   genvar k;
   generate
      for (k = 0; k < NB; k++) begin : g_cmp
         assign at_or_above[k] = (addr >= bnd[k]);
      end
   endgenerate

   // highest boundary passed wins
   always_comb begin
      area = '0;
      for (int j = 0; j < NB; j++) begin
         if (at_or_above[j]) area = AREA_W'(j + 1);
      end
   end

   // R3: the topmost boundary the address reaches always selects the top area
   always_comb begin
      p_top_area_r3: assert (!(addr >= bnd[NB-1]) || (int'(area) == NB));
   end
endmodule

// File: rtl/spl_cfg_regs.sv
module spl_cfg_regs
   import spl_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int GB      = 9,
   parameter int LW      = 23,
   parameter int NI      = 3,
   parameter int ND      = 2,
   parameter int IDX_W   = 4,
   parameter int IPW     = 12,
   parameter int DPW     = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       idx,
   input  logic [ADDR_W-1:0]      wdata,
   output logic [NI-1:0][LW-1:0]  ins_line,
   output logic [ND-1:0][LW-1:0]  dat_line,
   output logic [IPW-1:0]         ins_perm,
   output logic [DPW-1:0]         dat_perm,
   output logic [1:0]             mon_en
);
   localparam int IDX_IPERM = NI + ND;
   localparam int IDX_DPERM = NI + ND + 1;
   localparam int IDX_LOCK  = NI + ND + 2;
   localparam int IDX_MON   = NI + ND + 3;

   generate
      if (IDX_MON >= (1 << IDX_W)) begin : g_bad_idx
         $error("IDX_W too small for register map");
      end
      if (IPW > ADDR_W || DPW > ADDR_W || LW != ADDR_W - GB) begin : g_bad_w
         $error("field widths inconsistent with ADDR_W");
      end
   endgenerate

   logic [LOCK_BITS-1:0] lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_line <= '0;
         dat_line <= '0;
         ins_perm <= '0;
         dat_perm <= '0;
         lock_q   <= '0;
         mon_en   <= '0;
      end else if (we) begin
         for (int i = 0; i < NI; i++) begin
            if (idx == IDX_W'(i) && !lock_q[LOCK_SPLIT]) ins_line[i] <= wdata[ADDR_W-1:GB];
         end
         for (int i = 0; i < ND; i++) begin
            if (idx == IDX_W'(NI + i) && !lock_q[LOCK_SPLIT]) dat_line[i] <= wdata[ADDR_W-1:GB];
         end
         if (idx == IDX_W'(IDX_IPERM) && !lock_q[LOCK_IPERM]) ins_perm <= wdata[IPW-1:0];
         if (idx == IDX_W'(IDX_DPERM) && !lock_q[LOCK_DPERM]) dat_perm <= wdata[DPW-1:0];
         if (idx == IDX_W'(IDX_LOCK)) lock_q <= lock_q | wdata[LOCK_BITS-1:0];
         if (idx == IDX_W'(IDX_MON))  mon_en <= wdata[1:0];
      end
   end

   // R5: a set lock bit never drops
   p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
   // R4: split lines frozen under the split lock
   p_lines_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[LOCK_SPLIT] |=> ($stable(ins_line) && $stable(dat_line)));
   // R6: each permission field frozen under its own lock
   p_iperm_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[LOCK_IPERM] |=> $stable(ins_perm));
   p_dperm_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[LOCK_DPERM] |=> $stable(dat_perm));
endmodule

// File: rtl/spl_perm_checker.sv
module spl_perm_checker
   import spl_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          GRAN_BITS   = 9,
   parameter int          INS_LINES   = 3,
   parameter int          DATA_LINES  = 2,
   parameter logic [31:0] DATA_OFFSET = 32'h0010_0000,
   parameter int          IDX_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              acc_valid,
   input  logic              acc_dwin,
   input  logic [1:0]        acc_op,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              violation
);
   localparam int LW     = ADDR_W - GRAN_BITS;
   localparam int IAREAS = INS_LINES + 1;
   localparam int DBNDS  = DATA_LINES + 1;
   localparam int DAREAS = DBNDS + 1;
   localparam int IAW    = $clog2(IAREAS);
   localparam int DAW    = $clog2(DAREAS);
   localparam int IPW    = 3 * IAREAS;
   localparam int DPW    = 2 * DAREAS;

   generate
      if (GRAN_BITS < 1 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
         $error("GRAN_BITS out of range");
      end
      if (INS_LINES < 1 || DATA_LINES < 1) begin : g_bad_lines
         $error("need at least one line per window");
      end
   endgenerate

   logic [INS_LINES-1:0][LW-1:0]      ins_line;
   logic [DATA_LINES-1:0][LW-1:0]     dat_line;
   logic [IPW-1:0]                    ins_perm;
   logic [DPW-1:0]                    dat_perm;
   logic [1:0]                        mon_en;
   logic [INS_LINES-1:0][ADDR_W-1:0]  ins_bnd;
   logic [DBNDS-1:0][ADDR_W-1:0]      dat_bnd;
   logic [IAW-1:0]                    i_area;
   logic [DAW-1:0]                    d_area;
   logic [2:0]                        i_rwx;
   logic [1:0]                        d_rw;
   logic                              allowed;
   spl_op_e                           op;

   spl_cfg_regs #(
      .ADDR_W(ADDR_W), .GB(GRAN_BITS), .LW(LW), .NI(INS_LINES), .ND(DATA_LINES),
      .IDX_W(IDX_W), .IPW(IPW), .DPW(DPW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
      .ins_line(ins_line), .dat_line(dat_line), .ins_perm(ins_perm),
      .dat_perm(dat_perm), .mon_en(mon_en)
   );

   genvar k;
   generate
      for (k = 0; k < INS_LINES; k++) begin : g_ibnd
         assign ins_bnd[k] = {ins_line[k], {GRAN_BITS{1'b0}}};
      end
      for (k = 0; k < DATA_LINES; k++) begin : g_dbnd
         assign dat_bnd[k] = {dat_line[k], {GRAN_BITS{1'b0}}};
      end
   endgenerate
   assign dat_bnd[DBNDS-1] = {ins_line[INS_LINES-1], {GRAN_BITS{1'b0}}} + ADDR_W'(DATA_OFFSET);

   spl_area_decode #(.ADDR_W(ADDR_W), .NB(INS_LINES), .AREA_W(IAW)) u_idec (
      .addr(acc_addr), .bnd(ins_bnd), .area(i_area)
   );
   spl_area_decode #(.ADDR_W(ADDR_W), .NB(DBNDS), .AREA_W(DAW)) u_ddec (
      .addr(acc_addr), .bnd(dat_bnd), .area(d_area)
   );

   assign i_rwx = ins_perm[3*i_area +: 3];
   assign d_rw  = dat_perm[2*d_area +: 2];
   assign op    = spl_op_e'(acc_op);

   always_comb begin
      unique case (op)
         OP_READ:  allowed = acc_dwin ? d_rw[0] : i_rwx[0];
         OP_WRITE: allowed = acc_dwin ? d_rw[1] : i_rwx[1];
         OP_EXEC:  allowed = acc_dwin ? 1'b0    : i_rwx[2];
         default:  allowed = 1'b0;
      endcase
   end

   assign violation = acc_valid && mon_en[acc_dwin] && !allowed;

   // R9: idle bus never flags
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !violation);
   // R9: unmonitored instruction window never flags
   p_ins_unmon_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_dwin && !mon_en[MON_INS]) |-> !violation);
   // R8: monitored data execute always flags
   p_dexec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_dwin && acc_op == 2'd2 && mon_en[MON_DAT]) |-> violation);
endmodule

// File: tb/spl_perm_checker_test.sv
module spl_perm_checker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic        acc_dwin = 1'b0;
   logic [1:0]  acc_op = '0;
   logic [31:0] acc_addr = '0;
   logic        violation;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spl_perm_checker uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_dwin(acc_dwin),
      .acc_op(acc_op), .acc_addr(acc_addr), .violation(violation)
   );

   task automatic wr(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic acc(input string req, input logic v, input logic dw, input logic [1:0] op,
                      input logic [31:0] a, input logic exp);
      @(negedge clk);
      acc_valid = v; acc_dwin = dw; acc_op = op; acc_addr = a;
      #2;
      checks++;
      if (violation !== exp) begin
         errors++;
         $display("FAIL %s addr=%h dwin=%0d op=%0d violation=%0b expected=%0b",
                  req, a, dw, op, violation, exp);
      end
      acc_valid = 1'b0;
   endtask

   task automatic t_reset;
      acc("R1", 1, 0, 1, 32'h0000_0000, 0);
      acc("R1", 1, 0, 2, 32'h1234_5678, 0);
      acc("R1", 1, 1, 2, 32'h0000_0400, 0);
      acc("R1", 1, 0, 3, 32'hFFFF_FFFF, 0);
   endtask

   task automatic t_ins_areas;
      wr(4'd0, 32'h0000_1000);
      wr(4'd1, 32'h0000_2000);
      wr(4'd2, 32'h0000_31FF);        // truncated to 0x3000
      wr(4'd5, 32'h0000_0711);        // a0=r a1=w a2=x a3=rw
      wr(4'd8, 32'h0000_0001);
      acc("R3", 1, 0, 0, 32'h0000_0FFF, 0);
      acc("R7", 1, 0, 1, 32'h0000_0FFF, 1);
      acc("R3", 1, 0, 1, 32'h0000_1000, 0);
      acc("R7", 1, 0, 0, 32'h0000_1000, 1);
      acc("R3", 1, 0, 1, 32'h0000_1FFF, 0);
      acc("R3", 1, 0, 2, 32'h0000_2000, 0);
      acc("R7", 1, 0, 0, 32'h0000_2000, 1);
      acc("R3", 1, 0, 2, 32'h0000_2FFF, 0);
      acc("R2", 1, 0, 0, 32'h0000_3000, 0);
      acc("R7", 1, 0, 2, 32'h0000_3000, 1);
      acc("R3", 1, 0, 1, 32'hFFFF_FFFF, 0);
      acc("R7", 1, 0, 3, 32'h0000_3000, 1);
   endtask

   task automatic t_data_areas;
      wr(4'd3, 32'h0000_0800);
      wr(4'd4, 32'h0000_1000);
      wr(4'd6, 32'h0000_0039);        // a0=r a1=w a2=rw a3=none
      wr(4'd8, 32'h0000_0003);
      acc("R8", 1, 1, 0, 32'h0000_07FF, 0);
      acc("R8", 1, 1, 1, 32'h0000_07FF, 1);
      acc("R8", 1, 1, 1, 32'h0000_0800, 0);
      acc("R8", 1, 1, 0, 32'h0000_0800, 1);
      acc("R8", 1, 1, 0, 32'h0000_1000, 0);
      acc("R8", 1, 1, 1, 32'h0010_2FFF, 0);
      acc("R8", 1, 1, 0, 32'h0010_3000, 1);
      acc("R8", 1, 1, 2, 32'h0000_1000, 1);
      acc("R8", 1, 0, 0, 32'h0000_1000, 1);  // same address, instruction side
   endtask

   task automatic t_monitor;
      wr(4'd8, 32'h0000_0001);
      acc("R9", 1, 1, 0, 32'h0010_3000, 0);
      acc("R9", 1, 0, 1, 32'h0000_0FFF, 1);
      wr(4'd8, 32'h0000_0002);
      acc("R9", 1, 0, 1, 32'h0000_0FFF, 0);
      acc("R9", 1, 1, 0, 32'h0010_3000, 1);
      acc("R9", 0, 1, 0, 32'h0010_3000, 0);
      wr(4'd8, 32'h0000_0003);
   endtask

   task automatic t_locks;
      wr(4'd7, 32'h0000_0002);        // instruction permission lock
      wr(4'd5, 32'h0000_0000);
      acc("R6", 1, 0, 0, 32'h0000_0FFF, 0);
      wr(4'd6, 32'h0000_00FF);        // data perms still open
      acc("R6", 1, 1, 0, 32'h0010_3000, 0);
      wr(4'd7, 32'h0000_0001);        // split lock
      wr(4'd0, 32'h0000_0000);
      acc("R4", 1, 0, 1, 32'h0000_0FFF, 1);
      wr(4'd1, 32'h0000_F000);
      acc("R4", 1, 0, 2, 32'h0000_2000, 0);
      wr(4'd2, 32'h0000_0000);
      acc("R4", 1, 0, 0, 32'h0000_2000, 1);
      wr(4'd3, 32'h0000_0000);
      wr(4'd6, 32'h0000_0001);        // only data area 0 read, not yet locked
      acc("R4", 1, 1, 0, 32'h0000_0400, 0);
      acc("R6", 1, 1, 0, 32'h0000_0800, 1);
      wr(4'd7, 32'h0000_0004);        // data permission lock
      wr(4'd6, 32'h0000_00FF);
      acc("R6", 1, 1, 0, 32'h0000_0800, 1);
      wr(4'd7, 32'h0000_0000);        // must not clear
      wr(4'd5, 32'h0000_0FFF);
      acc("R5", 1, 0, 1, 32'h0000_0FFF, 1);
      wr(4'd0, 32'h0000_0000);
      acc("R5", 1, 0, 0, 32'h0000_0FFF, 0);
      wr(4'd6, 32'h0000_00FF);
      acc("R5", 1, 1, 1, 32'h0000_0400, 1);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_ins_areas;
      t_data_areas;
      t_monitor;
      t_locks;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule